// File: doc/BRIEF.md
# Multi-Source Interrupt Router and Level Mapper

This block is a system-level interrupt concentrator. It samples 32 level-sensitive device request lines into a pending register, applies a disable (mask) register and a global master-off bit, and maps every surviving source onto a processor priority level between 1 and 15. Several sources share a level. The resulting 16-bit level vector goes to exactly one processor, the current target, and the other processors see zero.

Software reaches the block through a word-addressed register port. Writes use set or clear semantics on the disable register, so a driver changes only the bits it names. Another word selects the target processor. Reads return the pending state and the writable part of the mask. The processor count is a power-of-two parameter, and the output is one 16-bit vector per processor.

Top module: `irq_router`

## Requirements
- R1: Each register cycle, the pending register takes the value of `src_irq`. A high line sets its pending bit, and a low line clears it on the next rising edge.
- R2: Source bit n maps to a level. Bits 0 to 6 map to 2,3,5,7,9,11,13. Bits 7 to 13 map to the same seven levels. Bits 14 and 15 map to 12. Bit 16 maps to 6, 17 to 13, 18 to 4, 19 to 10, 20 to 8, 21 to 9 and 22 to 11. Bits 27 to 30 map to 15. Bits 23 to 26 and bit 31 map to 0, and a level-0 source is never delivered.
- R3: Only disable bits inside 0xF05DFF80 can be written. Every other disable bit keeps its reset value.
- R4: A write to word 2 clears the written bits of the disable register, which enables those sources. A write to word 3 sets them. Neither write changes pending.
- R5: Reading word 0 returns pending with bit 31 forced to 0. Reading word 1 returns the disable register ANDed with 0xF05DFF80.
- R6: While disable bit 31 (master off) is set, every processor's level vector is zero.
- R7: A write to word 4 sets the target processor to the written value modulo NCPU.
- R8: Only the target processor's vector can be nonzero. Its bit L is 1 exactly when some pending, non-disabled source maps to level L, and bit 0 is always 0.
- R9: After reset, pending is 0, the target is processor 0, the disable register is 0x0FA2007F and all outputs are zero.
- R10: Reads of words 5 to 7 return 0, and writes to them change nothing.
- R11: A mask or target write is visible on `hard_lvl` in the cycle right after the write edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_irq | input | 32 | Level-sensitive device request lines |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Word offset of the register access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| hard_lvl | output | NCPU*16 | Per-processor level vectors; processor c uses bits c*16+15 to c*16 |

## Verification
The assertions assume that `reg_addr` and `reg_wdata` are stable and defined whenever `reg_wr` is high, and that `src_irq` holds no X values. The bench changes every input only at the falling edge, from a seeded `$urandom` stream. Write data is biased so that master-off is set in only a minority of disable writes, so delivery to the target is exercised often. Target values are drawn wider than NCPU to exercise the modulo wrap, and accesses to words 5 to 7 are mixed into the random traffic.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;

    localparam int SRC_N   = 32;
    localparam int LVL_N   = 16;
    localparam int ADDR_W  = 3;
    localparam int LVL_W   = 4;
    localparam int MASTER  = 31;

    localparam logic [SRC_N-1:0] WR_MASK = 32'hF05D_FF80;
    localparam logic [SRC_N-1:0] DIS_RST = 32'h0FA2_007F;

    typedef enum logic [ADDR_W-1:0] {
        OFS_PEND    = 3'd0,
        OFS_MASK    = 3'd1,
        OFS_ENABLE  = 3'd2,
        OFS_DISABLE = 3'd3,
        OFS_TARGET  = 3'd4
    } reg_ofs_e;

    // priority level for one source bit; 0 = never delivered
    function automatic logic [LVL_W-1:0] src_level(input int idx);
        logic [LVL_W-1:0] lv;
        case (idx)
            0, 7:           lv = 4'd2;
            1, 8:           lv = 4'd3;
            2, 9:           lv = 4'd5;
            3, 10:          lv = 4'd7;
            4, 11, 21:      lv = 4'd9;
            5, 12, 22:      lv = 4'd11;
            6, 13, 17:      lv = 4'd13;
            14, 15:         lv = 4'd12;
            16:             lv = 4'd6;
            18:             lv = 4'd4;
            19:             lv = 4'd10;
            20:             lv = 4'd8;
            27, 28, 29, 30: lv = 4'd15;
            default:        lv = 4'd0;
        endcase
        return lv;
    endfunction

    // set of source bits that feed a given level
    function automatic logic [SRC_N-1:0] level_members(input int lvl);
        logic [SRC_N-1:0] m;
        m = '0;
        for (int i = 0; i < SRC_N; i++) begin
            m[i] = (int'(src_level(i)) == lvl);
        end
        return m;
    endfunction

endpackage

// File: rtl/irq_regfile.sv
module irq_regfile
    import irq_router_pkg::*;
#(
    parameter int NCPU  = 4,
    parameter int TGT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SRC_N-1:0]  src_irq,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [SRC_N-1:0]  wdata,
    output logic [SRC_N-1:0]  pend_q,
    output logic [SRC_N-1:0]  dis_q,
    output logic [TGT_W-1:0]  tgt_q,
    output logic [SRC_N-1:0]  rdata
);

    logic [SRC_N-1:0] wbits;
    assign wbits = wdata & WR_MASK;

    // pending follows the request lines every cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else begin
            pend_q <= src_irq;
        end
    end

    // disable register and target select
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dis_q <= DIS_RST;
            tgt_q <= '0;
        end else if (wr_en) begin
            case (addr)
                OFS_ENABLE:  dis_q <= dis_q & ~wbits;
                OFS_DISABLE: dis_q <= dis_q | wbits;
                OFS_TARGET:  tgt_q <= wdata[TGT_W-1:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        case (addr)
            OFS_PEND: rdata = pend_q & ~(SRC_N'(1) << MASTER);
            OFS_MASK: rdata = dis_q & WR_MASK;
            default:  rdata = '0;
        endcase
    end

endmodule

// File: rtl/irq_level_map.sv
module irq_level_map
    import irq_router_pkg::*;
(
    input  logic [SRC_N-1:0] active,
    output logic [LVL_N-1:0] lvl_vec
);

    for (genvar lv = 0; lv < LVL_N; lv++) begin : g_lvl
        if (lv == 0) begin : g_none
            assign lvl_vec[lv] = 1'b0;
        end else begin : g_or
            localparam logic [SRC_N-1:0] MEMBERS = level_members(lv);
            assign lvl_vec[lv] = |(active & MEMBERS);
        end
    end

endmodule

// File: rtl/irq_fanout.sv
module irq_fanout
    import irq_router_pkg::*;
#(
    parameter int NCPU  = 4,
    parameter int TGT_W = 2
) (
    input  logic [LVL_N-1:0]      lvl_vec,
    input  logic [TGT_W-1:0]      tgt,
    input  logic                  master_off,
    output logic [NCPU*LVL_N-1:0] hard_lvl
);

    for (genvar c = 0; c < NCPU; c++) begin : g_cpu
        logic sel;
        assign sel = (int'(tgt) == c) && !master_off;
        assign hard_lvl[c*LVL_N +: LVL_N] = sel ? lvl_vec : '0;
    end

endmodule

// File: rtl/irq_router.sv
module irq_router
    import irq_router_pkg::*;
#(
    parameter int NCPU = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [31:0]           src_irq,
    input  logic                  reg_wr,
    input  logic [2:0]            reg_addr,
    input  logic [31:0]           reg_wdata,
    output logic [31:0]           reg_rdata,
    output logic [NCPU*16-1:0]    hard_lvl
);

    localparam int TGT_W = (NCPU > 1) ? $clog2(NCPU) : 1;

    logic [SRC_N-1:0] pend_q;
    logic [SRC_N-1:0] dis_q;
    logic [TGT_W-1:0] tgt_q;
    logic [SRC_N-1:0] active;
    logic [LVL_N-1:0] lvl_vec;

    irq_regfile #(.NCPU(NCPU), .TGT_W(TGT_W)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .src_irq(src_irq),
        .wr_en  (reg_wr),
        .addr   (reg_addr),
        .wdata  (reg_wdata),
        .pend_q (pend_q),
        .dis_q  (dis_q),
        .tgt_q  (tgt_q),
        .rdata  (reg_rdata)
    );

    assign active = pend_q & ~dis_q;

    irq_level_map u_map (
        .active (active),
        .lvl_vec(lvl_vec)
    );

    irq_fanout #(.NCPU(NCPU), .TGT_W(TGT_W)) u_fan (
        .lvl_vec   (lvl_vec),
        .tgt       (tgt_q),
        .master_off(dis_q[MASTER]),
        .hard_lvl  (hard_lvl)
    );

endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk
    import irq_router_pkg::*;
#(
    parameter int NCPU = 4
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [31:0]           src_irq,
    input logic                  reg_wr,
    input logic [2:0]            reg_addr,
    input logic [31:0]           reg_wdata,
    input logic [31:0]           reg_rdata,
    input logic [NCPU*16-1:0]    hard_lvl,
    input logic [31:0]           pend_q,
    input logic [31:0]           dis_q
);

    logic [NCPU-1:0] busy;
    logic [NCPU-1:0] lvl0;
    logic [31:0]     wbits;

    assign wbits = reg_wdata & WR_MASK;

    for (genvar c = 0; c < NCPU; c++) begin : g_cpu
        assign busy[c] = |hard_lvl[c*16 +: 16];
        assign lvl0[c] = hard_lvl[c*16];
    end

    AST_PEND_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> pend_q == $past(src_irq)); // R1

    AST_FIXED_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (dis_q & ~WR_MASK) == (DIS_RST & ~WR_MASK)); // R3

    AST_DISABLE_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 3'd3) |=> ((dis_q & $past(wbits)) == $past(wbits))); // R4

    AST_ENABLE_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 3'd2) |=> ((dis_q & $past(wbits)) == '0)); // R4

    AST_PEND_TOP_HIDDEN: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == 3'd0) |-> !reg_rdata[31]); // R5

    AST_MASTER_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        dis_q[31] |-> hard_lvl == '0); // R6

    AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(busy)); // R8

    AST_NO_LEVEL0: assert property (@(posedge clk) disable iff (!rst_n)
        lvl0 == '0); // R8

    AST_HOLE_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr > 3'd4) |-> reg_rdata == '0); // R10

endmodule

bind irq_router irq_router_chk #(.NCPU(NCPU)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .src_irq  (src_irq),
    .reg_wr   (reg_wr),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata),
    .hard_lvl (hard_lvl),
    .pend_q   (pend_q),
    .dis_q    (dis_q)
);

// File: tb/irq_router_tb.sv
`timescale 1ns/1ps
module irq_router_tb;

    localparam int NCPU = 4;
    localparam logic [31:0] WM  = 32'hF05D_FF80;
    localparam logic [31:0] DRS = 32'h0FA2_007F;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic [31:0]         src_irq = '0;
    logic                reg_wr = 1'b0;
    logic [2:0]          reg_addr = '0;
    logic [31:0]         reg_wdata = '0;
    logic [31:0]         reg_rdata;
    logic [NCPU*16-1:0]  hard_lvl;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    logic [31:0] m_pend, m_dis;
    int          m_tgt;

    always #2.5 clk = ~clk;

    irq_router #(.NCPU(NCPU)) u_dut (
        .clk(clk), .rst_n(rst_n), .src_irq(src_irq), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .hard_lvl(hard_lvl)
    );

    function automatic int lvl_of(input int n);
        int t[31:0];
        t = '{0,15,15,15,15,0,0,0,0,11,9,8,10,4,13,6,12,12,13,11,9,7,5,3,2,13,11,9,7,5,3,2};
        return t[n];
    endfunction

    function automatic logic [NCPU*16-1:0] exp_lvl();
        logic [15:0] v = '0;
        logic [NCPU*16-1:0] o = '0;
        logic [31:0] act = m_pend & ~m_dis;
        for (int i = 0; i < 32; i++)
            if (act[i] && lvl_of(i) != 0) v[lvl_of(i)] = 1'b1;
        if (!m_dis[31]) o[m_tgt*16 +: 16] = v;
        return o;
    endfunction

    function automatic logic [31:0] exp_rd(input logic [2:0] a);
        if (a == 3'd0) return {1'b0, m_pend[30:0]};
        if (a == 3'd1) return m_dis & WM;
        return '0;
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic cyc(input logic wr, input logic [2:0] a, input logic [31:0] d,
                       input logic [31:0] s, input string req);
        reg_wr = wr; reg_addr = a; reg_wdata = d; src_irq = s;
        @(posedge clk);
        m_pend = s;
        if (wr) begin
            if (a == 3'd2) m_dis = m_dis & ~(d & WM);
            else if (a == 3'd3) m_dis = m_dis | (d & WM);
            else if (a == 3'd4) m_tgt = int'(d % NCPU);
        end
        @(negedge clk);
        reg_wr = 1'b0;
        chk(req, 64'(hard_lvl), 64'(exp_lvl()));
        chk(req, 64'(reg_rdata), 64'(exp_rd(a)));
    endtask

    task automatic peek(input logic [2:0] a, input string req);
        reg_addr = a;
        #1;
        chk(req, 64'(reg_rdata), 64'(exp_rd(a)));
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog act=running exp=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        m_pend = '0; m_dis = DRS; m_tgt = 0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R9 reset state
        chk("R9", 64'(hard_lvl), 64'd0);
        peek(3'd0, "R9");
        peek(3'd1, "R9");
        // R1 R2 R5: all lines high, reset mask
        cyc(1'b0, 3'd0, '0, 32'hFFFF_FFFF, "R5");
        cyc(1'b0, 3'd0, '0, 32'hFFFF_FFFF, "R2");
        // R6 master off and R3 mask readback
        cyc(1'b1, 3'd3, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R6");
        cyc(1'b0, 3'd1, '0, 32'hFFFF_FFFF, "R3");
        // R4 pending unchanged by mask writes
        cyc(1'b1, 3'd2, 32'h8000_0000, 32'hFFFF_FFFF, "R4");
        peek(3'd0, "R4");
        // R11 enable source 8 -> level 3 next cycle
        cyc(1'b1, 3'd2, 32'h0000_0100, 32'hFFFF_FFFF, "R11");
        chk("R11", 64'(hard_lvl), 64'h8);
        // R7 target wrap: 6 mod 4 = 2
        cyc(1'b1, 3'd4, 32'd6, 32'hFFFF_FFFF, "R7");
        chk("R8", 64'(hard_lvl), 64'h8 << 32);
        // R3 locked bits: enabling sources 0..6 has no effect
        cyc(1'b1, 3'd2, 32'h0000_007F, 32'h0000_007F, "R3");
        chk("R3", 64'(hard_lvl), 64'd0);
        // R10 hole writes and reads
        cyc(1'b1, 3'd5, 32'hFFFF_FFFF, 32'h0000_0100, "R10");
        cyc(1'b1, 3'd7, 32'h0000_0003, 32'h0000_0100, "R10");
        cyc(1'b0, 3'd6, '0, 32'h0000_0100, "R10");
        chk("R10", 64'(hard_lvl), 64'h8 << 32);
        // R1 line drop clears pending
        cyc(1'b0, 3'd0, '0, 32'h0, "R1");
        // random traffic
        for (int n = 0; n < 4000; n++) begin
            int op = $urandom_range(0, 99);
            logic [31:0] s = $urandom;
            logic [31:0] d = $urandom;
            if ($urandom_range(0, 3) != 0) d[31] = 1'b0;
            if (op < 25)      cyc(1'b1, 3'd2, d, s, "R4");
            else if (op < 45) cyc(1'b1, 3'd3, d, s, "R6");
            else if (op < 55) cyc(1'b1, 3'd4, $urandom_range(0, 15), s, "R7");
            else if (op < 62) cyc(1'b1, 3'($urandom_range(5, 7)), d, s, "R10");
            else              cyc(1'b0, 3'($urandom_range(0, 7)), d, s, "R2");
        end
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule